// File: doc/BRIEF.md
# BCD Clock-Calendar Counter

This block keeps the time of day and the calendar date in seven BCD registers: seconds, minutes, hours, day of week, date, month with a century bit, and year. A sub-second prescaler counts a 32.768 kHz enable input. When the count wraps it emits a one-cycle second tick, and a small step machine then ripples that tick through the fields, one field per clock cycle, stopping at the first field that does not wrap. The clock runs in either 24-hour mode or 12-hour mode with a PM bit. Month lengths, including 29 February in leap years, are derived from the stored month and year. Years 2000 to 2099 are covered.

A host loads any field through a byte write port and reads any field through a combinational read port. A write to the seconds register clears the sub-second count, so the next second ends a full prescale period after the write. The same count drives a 1 Hz phase output. This output goes high half a second into each second and low at the tick, and it serves later square-wave logic. When the oscillator-enable input is low, the prescaler stops, no tick occurs and time holds. Host writes still apply.

The step machine has seven states:
- `ST_IDLE`: waits for the tick, then moves to `ST_SEC`.
- `ST_SEC` and `ST_MIN`: each increments its field. When the field wraps 59 to 00, the machine moves on to `ST_MIN` or `ST_HOUR`; otherwise it returns to idle.
- `ST_HOUR`: steps the hour. On a midnight carry it moves to `ST_DATE`; otherwise it returns to idle.
- `ST_DATE`: advances the day of week and the date. At month end it moves to `ST_MONTH`.
- `ST_MONTH`: advances the month. At December it moves to `ST_YEAR`.
- `ST_YEAR`: advances the year and always returns to idle.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the registers read: seconds 00h, minutes 00h, hours 00h (24-hour midnight), day 01h, date 01h, month 01h with century 0, year 00h. Register addresses are 0 seconds, 1 minutes, 2 hours, 3 day, 4 date, 5 month, 6 year. Address 7 reads 00h.
- R2: One second passes for every PRESCALE enables while the oscillator is enabled. Seconds and minutes count 00 to 59 in BCD, and the wrap from 59 to 00 carries into the next field.
- R3: With hours bit 6 at 0 (24-hour mode), hours count 00 to 23 in BCD, with bit 5 as the tens bit for 20 to 23. Leaving 23 gives 00 and carries into the date.
- R4: With hours bit 6 at 1 (12-hour mode), bits 4:0 hold 01 to 12 in BCD and bit 5 is PM. Hour 11 steps to 12 with bit 5 inverted. Hour 12 steps to 01 with bit 5 kept. Only 11 PM to 12 AM carries into the date.
- R5: The day-of-week field (3 bits, 1 to 7) advances on every date carry, and 7 is followed by 1.
- R6: The date wraps to 01 and the month advances after the last day of the month. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. For February it is 29 when the BCD year is divisible by 4 (even tens digit with units 0, 4 or 8, or odd tens digit with units 2 or 6) and 28 otherwise.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and inverts the century bit, which is bit 7 of the month register.
- R8: A write to seconds clears the sub-second count. The 1 Hz phase is then low, rises after PRESCALE/2 further enables, and falls at the tick that ends the second. The tick comes after PRESCALE enables counted from the write.
- R9: While the oscillator enable is low, enables are ignored: the phase output and all fields hold. Host writes still apply.
- R10: A write is visible on the read port on the cycle after it is presented. Unused bits are dropped: bit 7 of seconds, minutes and hours; bits 7:3 of day; bits 7:6 of date; bits 6:5 of month.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | Oscillator running; low freezes timekeeping |
| tick_32k | input | 1 | 32.768 kHz count enable, one cycle per period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address for a write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Register address for a read |
| rd_data | output | 8 | Combinational read data |
| sec_tick | output | 1 | One-cycle pulse at each second boundary |
| phase_1hz | output | 1 | 1 Hz phase, high in the second half of each second |

## Verification
On every cycle, the assertions check:
- seconds stay valid BCD below 60;
- day and date never read zero;
- 12-hour values stay between 01 and 12;
- a seconds write clears the phase and blocks a tick;
- the step machine starts only after a tick;
- the century bit changes only on a host write or in the year step;
- nothing moves while the oscillator is stopped and no write is made.

Only the bench's sweeps can show that the values are correct. These sweeps cover the hour sequences in both modes, the day-of-week cycle, the month length for every month of all hundred years, and the year and century wrap. They also cover the exact number of enables before a tick and the phase timing after a seconds write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
    localparam logic [ADDR_W-1:0] A_DOW  = 3'd3;
    localparam logic [ADDR_W-1:0] A_DATE = 3'd4;
    localparam logic [ADDR_W-1:0] A_MON  = 3'd5;
    localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEC, ST_MIN, ST_HOUR, ST_DATE, ST_MONTH, ST_YEAR
    } step_e;

    // Two-digit BCD increment; callers handle the wrap of the field.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic en_in,
    input  logic clear,
    output logic tick,
    output logic phase
);
    localparam int CW   = $clog2(PRESCALE);
    localparam int HALF = PRESCALE / 2;
    localparam logic [CW-1:0] LAST_C = CW'(PRESCALE - 1);
    localparam logic [CW-1:0] HALF_C = CW'(HALF);

    logic [CW-1:0] cnt_q;
    logic          tick_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (clear) begin
                cnt_q <= '0;
            end else if (run && en_in) begin
                if (cnt_q == LAST_C) begin
                    cnt_q  <= '0;
                    tick_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign tick  = tick_q;
    assign phase = (cnt_q >= HALF_C);

    // R8: a seconds write never lets a tick through on the next cycle
    p_clear_kills_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !tick);
    // R2: a tick marks the start of a fresh sub-second count
    p_tick_at_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (cnt_q < HALF_C));
    // R9: a stopped oscillator freezes the sub-second count
    p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
    input  logic [6:0] hr_cur,
    output logic [6:0] hr_next,
    output logic       day_carry
);
    always_comb begin
        hr_next   = hr_cur;
        day_carry = 1'b0;
        if (hr_cur[6]) begin
            if (hr_cur[4:0] == 5'h11) begin
                hr_next   = {1'b1, ~hr_cur[5], 5'h12};
                day_carry = hr_cur[5];
            end else if (hr_cur[4:0] == 5'h12) begin
                hr_next = {1'b1, hr_cur[5], 5'h01};
            end else if (hr_cur[3:0] == 4'd9) begin
                hr_next = {1'b1, hr_cur[5], 5'h10};
            end else begin
                hr_next = {hr_cur[6:4], hr_cur[3:0] + 4'd1};
            end
        end else begin
            if (hr_cur[5:0] == 6'h23) begin
                hr_next   = 7'h00;
                day_carry = 1'b1;
            end else if (hr_cur[3:0] == 4'd9) begin
                hr_next = {1'b0, hr_cur[5:4] + 2'd1, 4'd0};
            end else begin
                hr_next = {hr_cur[6:4], hr_cur[3:0] + 4'd1};
            end
        end
    end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
    input  logic [4:0] mon,
    input  logic [7:0] yr,
    output logic [5:0] last_date
);
    logic leap;

    always_comb begin
        if (yr[4])
            leap = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
        else
            leap = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    end

    always_comb begin
        case (mon)
            5'h02:                      last_date = leap ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_date = 6'h30;
            default:                    last_date = 6'h31;
        endcase
    end
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
    import rtc_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      osc_en,
    input  logic                      tick_32k,
    input  logic                      wr_en,
    input  logic [rtc_pkg::ADDR_W-1:0] wr_addr,
    input  logic [rtc_pkg::DATA_W-1:0] wr_data,
    input  logic [rtc_pkg::ADDR_W-1:0] rd_addr,
    output logic [rtc_pkg::DATA_W-1:0] rd_data,
    output logic                      sec_tick,
    output logic                      phase_1hz
);
    step_e state_q, state_d;

    logic [6:0] sec_q, min_q, hours_q;
    logic [2:0] day_q;
    logic [5:0] date_q;
    logic [4:0] mon_q;
    logic       cent_q;
    logic [7:0] year_q;

    logic [7:0] sec_inc, min_inc, date_inc, mon_inc, year_inc;
    logic [6:0] hr_next;
    logic       hr_carry;
    logic [5:0] last_date;
    logic       sec_wr;

    assign sec_wr = wr_en && (wr_addr == A_SEC);

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (osc_en),
        .en_in (tick_32k),
        .clear (sec_wr),
        .tick  (sec_tick),
        .phase (phase_1hz)
    );

    rtc_hour_step u_hour (
        .hr_cur    (hours_q),
        .hr_next   (hr_next),
        .day_carry (hr_carry)
    );

    rtc_month_len u_mlen (
        .mon       (mon_q),
        .yr        (year_q),
        .last_date (last_date)
    );

    always_comb begin
        sec_inc  = bcd_inc({1'b0, sec_q});
        min_inc  = bcd_inc({1'b0, min_q});
        date_inc = bcd_inc({2'b00, date_q});
        mon_inc  = bcd_inc({3'b000, mon_q});
        year_inc = bcd_inc(year_q);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = sec_tick ? ST_SEC : ST_IDLE;
            ST_SEC:   state_d = (sec_q == 7'h59) ? ST_MIN : ST_IDLE;
            ST_MIN:   state_d = (min_q == 7'h59) ? ST_HOUR : ST_IDLE;
            ST_HOUR:  state_d = hr_carry ? ST_DATE : ST_IDLE;
            ST_DATE:  state_d = (date_q == last_date) ? ST_MONTH : ST_IDLE;
            ST_MONTH: state_d = (mon_q == 5'h12) ? ST_YEAR : ST_IDLE;
            ST_YEAR:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // field registers: step updates first, host writes override
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q   <= 7'h00;
            min_q   <= 7'h00;
            hours_q <= 7'h00;
            day_q   <= 3'd1;
            date_q  <= 6'h01;
            mon_q   <= 5'h01;
            cent_q  <= 1'b0;
            year_q  <= 8'h00;
        end else begin
            case (state_q)
                ST_SEC:   sec_q <= (sec_q == 7'h59) ? 7'h00 : sec_inc[6:0];
                ST_MIN:   min_q <= (min_q == 7'h59) ? 7'h00 : min_inc[6:0];
                ST_HOUR:  hours_q <= hr_next;
                ST_DATE: begin
                    day_q  <= (day_q == 3'd7) ? 3'd1 : day_q + 3'd1;
                    date_q <= (date_q == last_date) ? 6'h01 : date_inc[5:0];
                end
                ST_MONTH: mon_q <= (mon_q == 5'h12) ? 5'h01 : mon_inc[4:0];
                ST_YEAR: begin
                    if (year_q == 8'h99) begin
                        year_q <= 8'h00;
                        cent_q <= ~cent_q;
                    end else begin
                        year_q <= year_inc;
                    end
                end
                default: ;
            endcase
            if (wr_en) begin
                case (wr_addr)
                    A_SEC:  sec_q   <= wr_data[6:0];
                    A_MIN:  min_q   <= wr_data[6:0];
                    A_HOUR: hours_q <= wr_data[6:0];
                    A_DOW:  day_q   <= wr_data[2:0];
                    A_DATE: date_q  <= wr_data[5:0];
                    A_MON: begin
                        cent_q <= wr_data[7];
                        mon_q  <= wr_data[4:0];
                    end
                    A_YEAR: year_q  <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    // read port
    always_comb begin
        case (rd_addr)
            A_SEC:   rd_data = {1'b0, sec_q};
            A_MIN:   rd_data = {1'b0, min_q};
            A_HOUR:  rd_data = {1'b0, hours_q};
            A_DOW:   rd_data = {5'b0, day_q};
            A_DATE:  rd_data = {2'b0, date_q};
            A_MON:   rd_data = {cent_q, 2'b0, mon_q};
            A_YEAR:  rd_data = year_q;
            default: rd_data = 8'h00;
        endcase
    end

    // R2: seconds remain valid BCD below 60
    p_sec_bcd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q[3:0] <= 4'd9) && (sec_q[6:4] <= 3'd5));
    // R2: the carry chain only starts after a prescaler tick
    p_chain_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEC) |-> $past(sec_tick));
    // R4: 12-hour values stay within 01..12
    p_hour12_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hours_q[6] |-> ((hours_q[4:0] != 5'h00) && (hours_q[4:0] <= 5'h12)));
    // R5: day of week never reads zero
    p_day_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        day_q != 3'd0);
    // R6: date never reads zero
    p_date_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        date_q != 6'h00);
    // R7: century changes only by host write or the year step
    p_cent_only_year_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((cent_q != $past(cent_q)) && !$past(wr_en)) |-> ($past(state_q) == ST_YEAR));
    // R8: a seconds write leaves the phase low on the next cycle
    p_phase_low_after_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr |=> !phase_1hz);
    // R9: nothing advances while the oscillator is stopped
    p_hold_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !sec_tick && !osc_en && !wr_en)
            |=> ($stable(sec_q) && state_q == ST_IDLE && !sec_tick));
endmodule

// File: tb/rtc_bcd_calendar_bench.sv
module rtc_bcd_calendar_bench;
    localparam int PS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b1;
    logic       en32k = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_addr = 3'd0;
    logic [7:0] rd_data;
    logic       sec_tick;
    logic       phase_1hz;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    rtc_bcd_calendar #(.PRESCALE(PS)) u_rtc_bcd_calendar (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .tick_32k(en32k),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .sec_tick(sec_tick), .phase_1hz(phase_1hz)
    );

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        rd_addr = a;
        #0.5;
        check(req, rd_data, exp);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); en32k = 1'b1;
            @(negedge clk); en32k = 1'b0;
        end
    endtask

    task automatic one_second();
        pulses(PS);
        repeat (10) @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(3'd2, h);
        wr(3'd1, m);
        wr(3'd0, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R1: watchdog expired, got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values and address map
        rd_chk("R1 sec", 3'd0, 8'h00);
        rd_chk("R1 min", 3'd1, 8'h00);
        rd_chk("R1 hour", 3'd2, 8'h00);
        rd_chk("R1 day", 3'd3, 8'h01);
        rd_chk("R1 date", 3'd4, 8'h01);
        rd_chk("R1 month", 3'd5, 8'h01);
        rd_chk("R1 year", 3'd6, 8'h00);
        rd_chk("R1 addr7", 3'd7, 8'h00);

        // R10: write masking and next-cycle visibility
        wr(3'd2, 8'h92); rd_chk("R10 hour mask", 3'd2, 8'h12);
        wr(3'd5, 8'hE3); rd_chk("R10 month mask", 3'd5, 8'h83);
        wr(3'd3, 8'h0F); rd_chk("R10 day mask", 3'd3, 8'h07);
        wr(3'd4, 8'hD7); rd_chk("R10 date mask", 3'd4, 8'h17);
        wr(3'd7, 8'h55); rd_chk("R10 addr7 ignored", 3'd7, 8'h00);

        // R2: seconds sweep through a full minute
        set_time(8'h05, 8'h00, 8'h00);
        for (int i = 1; i <= 60; i++) begin
            one_second();
            rd_chk("R2 seconds", 3'd0, bcd(i % 60));
        end
        rd_chk("R2 minute carry", 3'd1, 8'h01);
        rd_chk("R2 hour untouched", 3'd2, 8'h05);

        // R3: 24-hour sweep
        for (int h = 0; h < 24; h++) begin
            wr(3'd4, 8'h10);
            set_time(bcd(h), 8'h59, 8'h59);
            one_second();
            rd_chk("R3 hour 24h", 3'd2, bcd((h + 1) % 24));
            rd_chk("R3 minute wrap", 3'd1, 8'h00);
            rd_chk("R3 date carry", 3'd4, (h == 23) ? 8'h11 : 8'h10);
        end

        // R4: 12-hour sweep, both halves of the day
        for (int pm = 0; pm < 2; pm++) begin
            for (int h = 1; h <= 12; h++) begin
                int nh; int npm;
                if (h == 11) begin nh = 12; npm = 1 - pm; end
                else if (h == 12) begin nh = 1; npm = pm; end
                else begin nh = h + 1; npm = pm; end
                wr(3'd4, 8'h10);
                set_time(8'h40 | 8'(pm << 5) | bcd(h), 8'h59, 8'h59);
                one_second();
                rd_chk("R4 hour 12h", 3'd2, 8'h40 | 8'(npm << 5) | bcd(nh));
                rd_chk("R4 date carry", 3'd4, (h == 11 && pm == 1) ? 8'h11 : 8'h10);
            end
        end

        // R5: day-of-week cycle
        for (int d = 1; d <= 7; d++) begin
            wr(3'd4, 8'h05);
            wr(3'd3, 8'(d));
            set_time(8'h23, 8'h59, 8'h59);
            one_second();
            rd_chk("R5 day of week", 3'd3, 8'((d % 7) + 1));
        end

        // R6 / R7: end of every month in every year
        for (int y = 0; y < 100; y++) begin
            for (int m = 1; m <= 12; m++) begin
                int nm; int ny;
                logic [7:0] em;
                nm = (m == 12) ? 1 : m + 1;
                ny = (m == 12) ? (y + 1) % 100 : y;
                em = bcd(nm) | ((m == 12 && y == 99) ? 8'h80 : 8'h00);
                wr(3'd6, bcd(y));
                wr(3'd5, bcd(m));
                wr(3'd4, bcd(mdays(m, y)));
                set_time(8'h23, 8'h59, 8'h59);
                one_second();
                rd_chk("R6 date wrap", 3'd4, 8'h01);
                rd_chk("R6 month step", 3'd5, em);
                rd_chk("R7 year step", 3'd6, bcd(ny));
            end
            // R6: 28 February step depends on leap year
            wr(3'd6, bcd(y));
            wr(3'd5, 8'h02);
            wr(3'd4, 8'h28);
            set_time(8'h23, 8'h59, 8'h59);
            one_second();
            rd_chk("R6 feb 28", 3'd4, (y % 4 == 0) ? 8'h29 : 8'h01);
            rd_chk("R6 feb month", 3'd5, (y % 4 == 0) ? 8'h02 : 8'h03);
        end

        // R7: century toggles back from 1 to 0
        wr(3'd6, 8'h99);
        wr(3'd5, 8'h92);
        wr(3'd4, 8'h31);
        set_time(8'h23, 8'h59, 8'h59);
        one_second();
        rd_chk("R7 century clear", 3'd5, 8'h01);
        rd_chk("R7 year wrap", 3'd6, 8'h00);

        // R8: phase timing after a seconds write
        set_time(8'h01, 8'h00, 8'h10);
        check("R8 phase after write", 8'(phase_1hz), 8'h00);
        pulses(PS / 2 - 1);
        check("R8 phase before half", 8'(phase_1hz), 8'h00);
        pulses(1);
        check("R8 phase at half", 8'(phase_1hz), 8'h01);
        pulses(PS / 2 - 1);
        repeat (10) @(negedge clk);
        check("R8 phase late", 8'(phase_1hz), 8'h01);
        rd_chk("R8 no early tick", 3'd0, 8'h10);
        pulses(1);
        check("R8 phase falls at tick", 8'(phase_1hz), 8'h00);
        repeat (10) @(negedge clk);
        rd_chk("R8 second done", 3'd0, 8'h11);
        pulses(5);
        wr(3'd0, 8'h30);
        check("R8 rewrite phase", 8'(phase_1hz), 8'h00);
        pulses(PS - 1);
        repeat (10) @(negedge clk);
        rd_chk("R8 rewrite restarts", 3'd0, 8'h30);
        pulses(1);
        repeat (10) @(negedge clk);
        rd_chk("R8 rewrite full second", 3'd0, 8'h31);

        // R9: stopped oscillator
        wr(3'd0, 8'h20);
        pulses(PS / 2 + 1);
        osc_en = 1'b0;
        pulses(3 * PS);
        repeat (10) @(negedge clk);
        check("R9 phase held", 8'(phase_1hz), 8'h01);
        rd_chk("R9 seconds held", 3'd0, 8'h20);
        wr(3'd1, 8'h42);
        rd_chk("R9 write while stopped", 3'd1, 8'h42);
        osc_en = 1'b1;
        pulses(PS / 2 - 1);
        repeat (10) @(negedge clk);
        rd_chk("R9 resumes", 3'd0, 8'h21);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule